// File: doc/BRIEF.md
# Cascadable Registered ALU Slice

A W-bit (default 16) three-bus arithmetic and logic slice. Two operand ports feed input registers that can be made transparent. Two operand multiplexers build an R and an S operand from the A and B values, the output register, or zero. An eight-function core combines R and S, and its result goes through an output register that can also be bypassed, and then to a three-state output port.

The slice produces a carry-out, a group propagate, a group generate, an overflow and a zero flag. Slices can therefore be chained in two ways:

- **Ripple carry:** the carry-out of each slice drives the carry-in of the next slice up.
- **External lookahead:** the propagate and generate terms of all slices go to a lookahead unit.

Choosing the output register as the S operand turns the slice into an accumulator. All registers clear on a synchronous active-low reset.

Top module: `alu_slice`

## Requirements
- R1: After reset, the input registers and the output register hold zero, and the registered flags hold zero except the zero flag, which is 1. The A register loads `a_in` on a rising edge only when `a_load_n` is 0. The B register loads `b_in` only when `b_load_n` is 0. Otherwise each register holds its value.
- R2: When `in_bypass` is 1, `a_in` and `b_in` reach the operand multiplexers directly and the input registers are not used. When `in_bypass` is 0, the register contents are used.
- R3: The output register captures the result and flags on a rising edge only when `f_load_n` is 0. When `out_bypass` is 1, the result and all five flags are the current combinational values. When `out_bypass` is 0, they are the registered values.
- R4: `op_sel` chooses the operands as follows:
  - 2'b00: R = A, S = output register.
  - 2'b01: R = A, S = 0.
  - 2'b10: R = 0, S = B.
  - 2'b11: R = A, S = B.
- R5: `fn_sel` 3'b000 gives all zeros, 3'b100 gives R^S, 3'b101 gives R|S, 3'b110 gives R&S, and 3'b111 gives all ones.
- R6: `fn_sel` 3'b001 gives S+~R+C, 3'b010 gives R+~S+C, and 3'b011 gives R+S+C, where C is `c_in`. `c_out` is the carry out of the top bit.
- R7: `zero` is 1 exactly when the W-bit result on the selected path is zero.
- R8: `ovf` is 1 on two's-complement overflow of the arithmetic operation.
- R9: For the arithmetic operations:
  - `grp_p` is 1 when every bit position of the effective adder operands propagates.
  - `grp_g` is 1 when the adder operands carry out with a carry-in of 0.
  - `c_out` equals `grp_g | (grp_p & c_in)`.
- R10: For the logic and constant codes, `c_out`, `ovf`, `grp_p` and `grp_g` are 0.
- R11: When `out_en_n` is 1, `f_bus` is high-impedance and `f_drv` is 0. When `out_en_n` is 0, `f_bus` carries the result and `f_drv` is 1.
- R12: The S operand under `op_sel` 2'b00 is the output register content even when `out_bypass` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | W | Operand A |
| b_in | input | W | Operand B |
| a_load_n | input | 1 | A register load enable, active low |
| b_load_n | input | 1 | B register load enable, active low |
| in_bypass | input | 1 | Input registers transparent when 1 |
| f_load_n | input | 1 | Output register load enable, active low |
| out_bypass | input | 1 | Output register transparent when 1 |
| op_sel | input | 2 | R/S operand selection |
| fn_sel | input | 3 | Function code |
| c_in | input | 1 | Carry in |
| out_en_n | input | 1 | Output enable, active low |
| f_bus | output | W | Three-state result |
| f_drv | output | 1 | High while f_bus is driven |
| c_out | output | 1 | Carry out |
| ovf | output | 1 | Two's-complement overflow |
| zero | output | 1 | Result is zero |
| grp_p | output | 1 | Group propagate |
| grp_g | output | 1 | Group generate |

## Verification
The bench builds the slice with the default width W=16. At this width, constrained random operands combined with directed values reach the following cases:

- The sign boundary at 16'h7FFF/16'h8000, which exercises overflow.
- The carry wrap at 16'hFFFF, which exercises carry and zero together.
- Equal-operand subtraction, where propagate is set and generate is clear.

Random choices of the bypass, enable and operand-select bits cover all four register/transparent combinations, including accumulation through the output register.

// File: rtl/alu_slice.sv
module alu_slice #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         a_load_n,
  input  logic         b_load_n,
  input  logic         in_bypass,
  input  logic         f_load_n,
  input  logic         out_bypass,
  input  logic [1:0]   op_sel,
  input  logic [2:0]   fn_sel,
  input  logic         c_in,
  input  logic         out_en_n,
  output logic [W-1:0] f_bus,
  output logic         f_drv,
  output logic         c_out,
  output logic         ovf,
  output logic         zero,
  output logic         grp_p,
  output logic         grp_g
);

  logic [W-1:0] a_q, b_q, f_q;
  logic         c_q, v_q, z_q, p_q, g_q;
  logic [W-1:0] a_eff, b_eff, r_op, s_op, x_op, y_op, res_n, f_val;
  logic [W:0]   sum, gen_sum;
  logic         is_arith, c_n, v_n, z_n, p_n, g_n;

  assign a_eff = in_bypass ? a_in : a_q;
  assign b_eff = in_bypass ? b_in : b_q;

  always_comb begin
    case (op_sel)
      2'b00:   begin r_op = a_eff; s_op = f_q;   end
      2'b01:   begin r_op = a_eff; s_op = '0;    end
      2'b10:   begin r_op = '0;    s_op = b_eff; end
      default: begin r_op = a_eff; s_op = b_eff; end
    endcase
  end

  assign is_arith = (fn_sel[2] == 1'b0) && (fn_sel != 3'b000);

  always_comb begin
    x_op = r_op;
    y_op = s_op;
    if (fn_sel == 3'b001) x_op = ~r_op;
    if (fn_sel == 3'b010) y_op = ~s_op;
  end

  assign sum     = {1'b0, x_op} + {1'b0, y_op} + {{W{1'b0}}, c_in};
  assign gen_sum = {1'b0, x_op} + {1'b0, y_op};

  always_comb begin
    case (fn_sel)
      3'b000:  res_n = '0;
      3'b100:  res_n = r_op ^ s_op;
      3'b101:  res_n = r_op | s_op;
      3'b110:  res_n = r_op & s_op;
      3'b111:  res_n = '1;
      default: res_n = sum[W-1:0];
    endcase
  end

  assign c_n = is_arith & sum[W];
  assign v_n = is_arith & (x_op[W-1] == y_op[W-1]) & (sum[W-1] != x_op[W-1]);
  assign p_n = is_arith & (&(x_op | y_op));
  assign g_n = is_arith & gen_sum[W];
  assign z_n = (res_n == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (!a_load_n) a_q <= a_in;
      if (!b_load_n) b_q <= b_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_q <= '0;
      {c_q, v_q, p_q, g_q} <= '0;
      z_q <= 1'b1;
    end else if (!f_load_n) begin
      f_q <= res_n;
      {c_q, v_q, p_q, g_q} <= {c_n, v_n, p_n, g_n};
      z_q <= z_n;
    end
  end

  assign f_val = out_bypass ? res_n : f_q;
  assign c_out = out_bypass ? c_n : c_q;
  assign ovf   = out_bypass ? v_n : v_q;
  assign zero  = out_bypass ? z_n : z_q;
  assign grp_p = out_bypass ? p_n : p_q;
  assign grp_g = out_bypass ? g_n : g_q;

  assign f_drv = ~out_en_n;
  assign f_bus = out_en_n ? {W{1'bz}} : f_val;

  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    a_load_n |=> $stable(a_q)); // R1
  AST_F_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    f_load_n |=> $stable(f_q)); // R3
  AST_CARRY_LOOKAHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    is_arith |-> (c_n == (g_n | (p_n & c_in)))); // R9
  AST_LOGIC_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_bypass && !is_arith) |-> !(c_out | ovf | grp_p | grp_g)); // R10
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    zero == (f_val == '0)); // R7

endmodule

// File: tb/tb_alu_slice.sv
`timescale 1ns/1ps
module tb_alu_slice;
  logic        clk = 0, rst_n = 0;
  logic [15:0] a_in = 0, b_in = 0;
  logic        a_load_n = 1, b_load_n = 1, in_bypass = 0, f_load_n = 1, out_bypass = 0;
  logic [1:0]  op_sel = 0;
  logic [2:0]  fn_sel = 0;
  logic        c_in = 0, out_en_n = 0;
  logic [15:0] f_bus;
  logic        f_drv, c_out, ovf, zero, grp_p, grp_g;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] ma, mb, mf;
  logic [4:0]  mfl; // {g,p,v,c,z}

  always #2.5 clk = ~clk;

  alu_slice #(.W(16)) dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .a_load_n(a_load_n), .b_load_n(b_load_n), .in_bypass(in_bypass),
    .f_load_n(f_load_n), .out_bypass(out_bypass), .op_sel(op_sel),
    .fn_sel(fn_sel), .c_in(c_in), .out_en_n(out_en_n), .f_bus(f_bus),
    .f_drv(f_drv), .c_out(c_out), .ovf(ovf), .zero(zero),
    .grp_p(grp_p), .grp_g(grp_g));

  function automatic logic [20:0] model(input logic [15:0] r, input logic [15:0] s,
                                         input logic [2:0] fn, input logic ci);
    logic [15:0] x, y, res;
    int u, sv, gu;
    logic ar, c, v, p, g;
    x = (fn == 3'b001) ? ~r : r;
    y = (fn == 3'b010) ? ~s : s;
    ar = (fn == 3'b001) || (fn == 3'b010) || (fn == 3'b011);
    u  = int'(x) + int'(y) + int'(ci);
    gu = int'(x) + int'(y);
    sv = int'($signed(x)) + int'($signed(y)) + int'(ci);
    case (fn)
      3'b000:  res = 16'h0000;
      3'b100:  res = r ^ s;
      3'b101:  res = r | s;
      3'b110:  res = r & s;
      3'b111:  res = 16'hFFFF;
      default: res = u[15:0];
    endcase
    c = ar && (u > 65535);
    v = ar && (sv > 32767 || sv < -32768);
    p = ar && ((x | y) == 16'hFFFF);
    g = ar && (gu > 65535);
    return {g, p, v, c, (res == 16'h0000), res};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic [15:0] a, input logic [15:0] b,
                      input logic aln, input logic bln, input logic byp, input logic fln,
                      input logic obyp, input logic [1:0] op, input logic [2:0] fn,
                      input logic ci, input logic oen);
    logic [15:0] ae, be, r, s;
    logic [20:0] m, e;
    logic ar;
    @(negedge clk);
    a_in = a; b_in = b; a_load_n = aln; b_load_n = bln; in_bypass = byp;
    f_load_n = fln; out_bypass = obyp; op_sel = op; fn_sel = fn; c_in = ci; out_en_n = oen;
    #1;
    ae = byp ? a : ma;
    be = byp ? b : mb;
    case (op)
      2'b00: begin r = ae;    s = mf; end
      2'b01: begin r = ae;    s = 0;  end
      2'b10: begin r = 16'h0; s = be; end
      default: begin r = ae;  s = be; end
    endcase
    m = model(r, s, fn, ci);
    e = obyp ? m : {mfl[4:1], mfl[0], mf};
    ar = obyp ? (fn == 3'b001 || fn == 3'b010 || fn == 3'b011) : 1'b1;
    chk("R11 drive", {15'b0, f_drv}, {15'b0, ~oen});
    if (!oen) chk(tag, f_bus, e[15:0]);
    chk("R7 zero", {15'b0, zero}, {15'b0, e[16]});
    chk(ar ? "R6 carry" : "R10 carry", {15'b0, c_out}, {15'b0, e[17]});
    chk(ar ? "R8 ovf" : "R10 ovf", {15'b0, ovf}, {15'b0, e[18]});
    chk(ar ? "R9 p" : "R10 p", {15'b0, grp_p}, {15'b0, e[19]});
    chk(ar ? "R9 g" : "R10 g", {15'b0, grp_g}, {15'b0, e[20]});
    @(posedge clk);
    if (!aln) ma = a;
    if (!bln) mb = b;
    if (!fln) begin mf = m[15:0]; mfl = m[20:16]; end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd7381);
    ma = 0; mb = 0; mf = 0; mfl = 5'b00001;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    step("R1 reset", 16'h1111, 16'h2222, 1, 1, 0, 1, 0, 2'b11, 3'b011, 0, 0);
    // R1 load then hold
    step("R1 load", 16'h1234, 16'h4321, 0, 0, 0, 1, 1, 2'b11, 3'b011, 0, 0);
    step("R1 hold", 16'hFFFF, 16'hFFFF, 1, 1, 0, 1, 1, 2'b01, 3'b011, 0, 0);
    step("R1 holdb", 16'hFFFF, 16'hFFFF, 1, 1, 0, 1, 1, 2'b10, 3'b011, 0, 0);
    // R2 bypass
    step("R2 bypass", 16'h00F0, 16'h0F00, 1, 1, 1, 1, 1, 2'b11, 3'b101, 0, 0);
    // R3 register and hold
    step("R3 load", 16'h7FFF, 16'h0001, 1, 1, 1, 0, 1, 2'b11, 3'b011, 0, 0);
    step("R3 hold", 16'h0000, 16'h0000, 1, 1, 1, 1, 0, 2'b11, 3'b000, 0, 0);
    step("R3 regout", 16'h0000, 16'h0000, 1, 1, 1, 1, 0, 2'b11, 3'b111, 0, 0);
    // R12 accumulate through register while bypassed
    for (int i = 0; i < 5; i++)
      step("R12 accum", 16'h0103, 16'h0, 1, 1, 1, 0, 1, 2'b00, 3'b011, 0, 0);
    // R8 / R6 / R9 corners
    step("R8 ovf", 16'h7FFF, 16'h0001, 1, 1, 1, 1, 1, 2'b11, 3'b011, 0, 0);
    step("R6 wrap", 16'hFFFF, 16'h0001, 1, 1, 1, 1, 1, 2'b11, 3'b011, 0, 0);
    step("R6 rminus", 16'h5A5A, 16'h5A5A, 1, 1, 1, 1, 1, 2'b11, 3'b010, 1, 0);
    step("R6 sminus", 16'h0001, 16'h8000, 1, 1, 1, 1, 1, 2'b11, 3'b001, 1, 0);
    step("R9 cin", 16'h8000, 16'h7FFF, 1, 1, 1, 1, 1, 2'b11, 3'b011, 1, 0);
    // R4 selections, R5 logic
    for (int o = 0; o < 4; o++)
      for (int f = 0; f < 8; f++)
        step((f[2] || f == 0) ? "R5 logic" : "R4 opsel", 16'hC3A5, 16'h5AF0,
             1, 1, 1, 1, 1, o[1:0], f[2:0], 1, 0);
    // R11 high-impedance
    step("R11 hiz", 16'h1, 16'h1, 1, 1, 1, 1, 1, 2'b11, 3'b011, 0, 1);
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ra, rb;
      logic [2:0] fn;
      ra = $urandom; rb = $urandom;
      if ($urandom_range(0, 7) == 0) ra = 16'h7FFF;
      if ($urandom_range(0, 7) == 0) rb = 16'hFFFF;
      fn = $urandom_range(0, 7);
      step((fn[2] || fn == 0) ? "R5 rand" : "R6 rand", ra, rb,
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3),
           fn, $urandom_range(0, 1), ($urandom_range(0, 9) == 0));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule